// File: doc/BRIEF.md
# SPI Port Controller

A byte-wide serial peripheral interface port with three byte registers behind a small address/strobe register bus: a control register, a status register and a data register. As master it generates the serial clock and an active-low select, shifts the written byte out and the incoming byte in, and flags completion. As slave it follows an external clock and select and exchanges a byte the same way. Bit order, clock idle level and the clock edge used for sampling are programmable; the master clock rate comes from one of four divisors.

A byte written to the data register while a transfer runs is rejected and recorded as a collision. The completion and collision flags are sticky and are cleared only by reading the status register while a flag is set and then touching the data register. An interrupt line follows the completion flag when both the local and the global interrupt enables are set.

Top module: `spi_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x04, the status register (address 1) reads 0x00, `ss_n_o` is 1, `sck_o` is 0 and `irq` is 0. Control bits: 7 interrupt enable, 6 port enable, 5 LSB-first, 4 master, 3 clock idle level, 2 clock phase, 1:0 rate.
- R2: In master mode with the port enabled, a write to the data register (address 2) while idle starts a transfer: `ss_n_o` goes low on the write edge and returns high on the 16th SCK edge, at which point status bit 7 (completion) is set and the data register holds the received byte.
- R3: The master SCK half period is 2, 8, 32 or 64 clock cycles for rate 00, 01, 10, 11 (divisors 4, 16, 64, 128); the first SCK edge comes one half period after the write edge.
- R4: With control bit 5 set the byte leaves and arrives LSB first; with it clear, MSB first.
- R5: `sck_o` rests at the level of control bit 3 whenever no master transfer runs.
- R6: With clock phase 0 each bit is valid on the data output before the leading SCK edge and input is sampled on the leading edge; with phase 1 the output changes on the leading edge and input is sampled on the trailing edge.
- R7: A data register write during a transfer sets status bit 6 (collision) and changes neither the byte being sent nor the byte received.
- R8: Both flags stay set until a status read that sees a flag set is followed by a data register read or write; a data access with no such preceding status read leaves them set.
- R9: `irq` is 1 exactly when status bit 7, control bit 7 and `serial_int_en` are all 1.
- R10: In slave mode a transfer advances only while `ss_n_i` is low; raising `ss_n_i` restarts the bit count, so completion is flagged only after 8 consecutive bits under one select; the rate bits have no effect.
- R11: The data register keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| serial_int_en | input | 1 | Global serial interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven as master |
| ss_n_o | output | 1 | Active-low select driven as master |
| sck_i | input | 1 | Serial clock received as slave |
| ss_n_i | input | 1 | Active-low select received as slave |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
As master, the first SCK edge is due H cycles after the write edge and every further edge H cycles later, with `ss_n_o` high and the completion flag set at edge 16H; the bench counts cycles from the write edge and compares `sck_o` and `ss_n_o` against that count on every falling clock edge, moving its own slave data only at the edges it has predicted. Register reads are combinational and flags appear one edge after their cause, so reads are sampled in the cycle after the triggering strobe. As slave the port reacts about three cycles after a pin edge through its synchronizer, and the bench holds each SCK level for ten cycles so that sampling falls well inside a stable window.

// File: rtl/spi_port_pkg.sv
// Shared register addresses, control layout and sizes for the SPI port.
package spi_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam logic [BYTE_W-1:0] CTRL_RST = 8'h04;

endpackage

// File: rtl/spi_rate_gen.sv
// Master half-period tick generator.
// Emits a one-cycle tick every H cycles while run is high, H chosen by rate.
// Assumes H3 is the largest half period and every half period is at least 2.
module spi_rate_gen #(
    parameter int H0 = 2,
    parameter int H1 = 8,
    parameter int H2 = 32,
    parameter int H3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int CW = $clog2(H3);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the terminal count for the programmed rate.
    always_comb begin
        case (rate)
            2'd0:    lim = CW'(H0 - 1);
            2'd1:    lim = CW'(H1 - 1);
            2'd2:    lim = CW'(H2 - 1);
            default: lim = CW'(H3 - 1);
        endcase
    end

    assign tick = run && (cnt == lim);

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_pin_sync.sv
// Synchronizes the slave clock and select pins and flags clock transitions.
// Assumes STAGES >= 2; the select resets to inactive (high).
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    output logic sck_lvl,
    output logic sck_edge,
    output logic ss_n_lvl
);
    logic [STAGES:0] sck_pipe;
    logic [STAGES:0] ss_pipe;

    // Shift both pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            ss_pipe  <= '1;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_i};
            ss_pipe  <= {ss_pipe[STAGES-1:0], ss_n_i};
        end
    end

    assign sck_lvl  = sck_pipe[STAGES-1];
    assign sck_edge = sck_pipe[STAGES-1] ^ sck_pipe[STAGES];
    assign ss_n_lvl = ss_pipe[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
// Byte shift register with bit counter shared by master and slave modes.
// Leading events sample (phase 0) or present (phase 1) a bit; trailing
// events shift. The shift register is not reset so the data survives reset.
module spi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lead_ev,
    input  logic         trail_ev,
    input  logic         clear_cnt,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         sdi,
    output logic [W-1:0] shreg,
    output logic         sdo,
    output logic         byte_done
);
    localparam int CNTW = $clog2(W);

    logic [CNTW-1:0] bitcnt;
    logic            samp;
    logic            out_bit;
    logic            first_bit;
    logic            in_bit;
    logic [W-1:0]    sh_next;

    assign first_bit = lsb_first ? shreg[0] : shreg[W-1];
    assign in_bit    = cpha ? sdi : samp;
    assign sh_next   = lsb_first ? {in_bit, shreg[W-1:1]} : {shreg[W-2:0], in_bit};
    assign sdo       = cpha ? out_bit : first_bit;
    assign byte_done = trail_ev && (bitcnt == CNTW'(W - 1));

    // Load a new byte or shift one bit on a trailing event.
    always_ff @(posedge clk) begin
        if (load)          shreg <= load_val;
        else if (trail_ev) shreg <= sh_next;
    end

    // Capture the input on a leading event and present the next output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp    <= 1'b0;
            out_bit <= 1'b0;
        end else if (lead_ev) begin
            samp    <= sdi;
            out_bit <= first_bit;
        end
    end

    // Count trailing events within a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bitcnt <= '0;
        else if (clear_cnt || byte_done) bitcnt <= '0;
        else if (trail_ev)               bitcnt <= bitcnt + 1'b1;
    end
endmodule

// File: rtl/spi_port.sv
// SPI port top: register file, flags, master sequencing and mode muxing.
// Assumes register strobes are single-cycle and one address per cycle.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int HALF_R0     = 2,
    parameter int HALF_R1     = 8,
    parameter int HALF_R2     = 32,
    parameter int HALF_R3     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              serial_int_en,
    output logic              irq,
    output logic              sck_o,
    output logic              ss_n_o,
    input  logic              sck_i,
    input  logic              ss_n_i,
    output logic              sdo,
    input  logic              sdi
);
    ctrl_t             ctrl_q;
    logic              spif_q, wcol_q, armed_q;
    logic              m_busy, sck_ph;
    logic              data_wr, data_rd, stat_rd, ctrl_wr;
    logic              master_en, xfer_busy, collide, load, m_start, clr_now;
    logic              tick, m_lead, m_trail;
    logic              s_lvl, s_edge, s_ssn, s_act, s_lead, s_trail;
    logic              lead_ev, trail_ev, clear_cnt, byte_done;
    logic [BYTE_W-1:0] shreg;

    assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
    assign data_wr   = wr_en && (addr == ADDR_DATA);
    assign data_rd   = rd_en && (addr == ADDR_DATA);
    assign stat_rd   = rd_en && (addr == ADDR_STAT);
    assign master_en = ctrl_q.enable && ctrl_q.master;
    assign s_act     = ctrl_q.enable && !ctrl_q.master && !s_ssn;
    assign xfer_busy = m_busy || s_act;
    assign collide   = data_wr && xfer_busy;
    assign load      = data_wr && !xfer_busy;
    assign m_start   = load && master_en;
    assign clr_now   = armed_q && (data_rd || data_wr);

    assign m_lead    = tick && !sck_ph;
    assign m_trail   = tick && sck_ph;
    assign s_lead    = s_act && s_edge && (s_lvl != ctrl_q.cpol);
    assign s_trail   = s_act && s_edge && (s_lvl == ctrl_q.cpol);
    assign lead_ev   = ctrl_q.master ? m_lead  : s_lead;
    assign trail_ev  = ctrl_q.master ? m_trail : s_trail;
    assign clear_cnt = ctrl_q.master ? m_start : !s_act;

    assign sck_o  = ctrl_q.cpol ^ sck_ph;
    assign ss_n_o = !m_busy;
    assign irq    = spif_q && ctrl_q.irq_en && serial_int_en;

    spi_rate_gen #(
        .H0(HALF_R0), .H1(HALF_R1), .H2(HALF_R2), .H3(HALF_R3)
    ) i_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (m_busy && master_en),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (sck_i),
        .ss_n_i  (ss_n_i),
        .sck_lvl (s_lvl),
        .sck_edge(s_edge),
        .ss_n_lvl(s_ssn)
    );

    spi_shift_core #(.W(BYTE_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wdata),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev),
        .clear_cnt(clear_cnt),
        .cpha     (ctrl_q.cpha),
        .lsb_first(ctrl_q.lsb_first),
        .sdi      (sdi),
        .shreg    (shreg),
        .sdo      (sdo),
        .byte_done(byte_done)
    );

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RST);
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata);
    end

    // Master busy: set by a start, cleared at the last edge or on disable.
    always_ff @(posedge clk) begin
        if (!rst_n)          m_busy <= 1'b0;
        else if (!master_en) m_busy <= 1'b0;
        else if (m_start)    m_busy <= 1'b1;
        else if (byte_done)  m_busy <= 1'b0;
    end

    // Master clock phase: toggles on each half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sck_ph <= 1'b0;
        else if (!(m_busy && master_en)) sck_ph <= 1'b0;
        else if (tick)                   sck_ph <= !sck_ph;
    end

    // Completion and collision flags with the read-then-access clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (byte_done)    spif_q <= 1'b1;
            else if (clr_now) spif_q <= 1'b0;
            if (collide)      wcol_q <= 1'b1;
            else if (clr_now) wcol_q <= 1'b0;
            if (clr_now)                          armed_q <= 1'b0;
            else if (stat_rd && (spif_q || wcol_q)) armed_q <= 1'b1;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = ctrl_q;
            ADDR_STAT: rdata = {spif_q, wcol_q, {(BYTE_W-2){1'b0}}};
            ADDR_DATA: rdata = shreg;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_port_chk.sv
// Temporal checks on the SPI port, attached to every instance by bind.
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic       sck_o,
    input logic       ss_n_o,
    input logic [7:0] ctrl_q,
    input logic       xfer_busy,
    input logic       wcol_q,
    input logic       spif_q,
    input logic       clr_now
);
    assert_collide_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2 && xfer_busy) |=> wcol_q);

    assert_wcol_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol_q) |-> $past(wr_en && addr == 2'd2 && xfer_busy));

    assert_spif_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spif_q && !clr_now) |=> spif_q);

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> (sck_o == ctrl_q[3]));

    assert_ss_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n_o) |-> $past(wr_en && addr == 2'd2));

    assert_sck_half_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n_o && $past(!ss_n_o) && (sck_o != $past(sck_o))) |=> $stable(sck_o));
endmodule

bind spi_port spi_port_chk i_spi_port_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .sck_o    (sck_o),
    .ss_n_o   (ss_n_o),
    .ctrl_q   (ctrl_q),
    .xfer_busy(xfer_busy),
    .wcol_q   (wcol_q),
    .spif_q   (spif_q),
    .clr_now  (clr_now)
);

// File: tb/test_spi_port.sv
// Bench: behavioural timing model of the master pins compared every cycle,
// a bench-side peer device for both modes, and register-level flag checks.
module test_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       serial_int_en = 1'b0;
    logic       irq;
    logic       sck_o, ss_n_o, sdo;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi = 1'b0;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] got;

    always #2 clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .serial_int_en(serial_int_en), .irq(irq),
        .sck_o(sck_o), .ss_n_o(ss_n_o), .sck_i(sck_i), .ss_n_i(ss_n_i),
        .sdo(sdo), .sdi(sdi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic bitof(input logic [7:0] b, input logic lsb, input int i);
        return lsb ? b[i] : b[7-i];
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        reg_read(a, v);
        chk(v == e, req, v, e);
    endtask

    // Master transfer against the bench peer; cj >= 0 injects a colliding write.
    task automatic master_run(input logic [7:0] ctl, input logic [7:0] tx,
                              input logic [7:0] peer, input int cj);
        int h, prev;
        logic cpol, cpha, lsb;
        h = (ctl[1:0] == 2'd0) ? 2 : (ctl[1:0] == 2'd1) ? 8 : (ctl[1:0] == 2'd2) ? 32 : 64;
        cpol = ctl[3]; cpha = ctl[2]; lsb = ctl[5];
        reg_write(2'd0, ctl);
        sdi = bitof(peer, lsb, 0);
        got = 8'h00; prev = 0;
        reg_write(2'd2, tx);
        for (int j = 0; j <= 16 * h + 1; j++) begin
            int tog, idx;
            tog = j / h;
            if (tog > 16) tog = 16;
            chk(sck_o == (cpol ^ tog[0]), "R3 R5 sck level", sck_o, cpol ^ tog[0]);
            chk(ss_n_o == (tog >= 16), "R2 select", ss_n_o, tog >= 16);
            if (tog != prev) begin
                idx = (tog - 1) / 2;
                if (tog[0]) begin
                    if (!cpha) got[lsb ? idx : 7 - idx] = sdo;
                    else       sdi = bitof(peer, lsb, idx);
                end else begin
                    if (!cpha) begin
                        if (idx < 7) sdi = bitof(peer, lsb, idx + 1);
                    end else got[lsb ? idx : 7 - idx] = sdo;
                end
                prev = tog;
            end
            if (j == cj) begin addr = 2'd2; wdata = 8'hFF; wr_en = 1'b1; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(got == tx, "R4 R6 R7 bits sent", got, tx);
    endtask

    task automatic clear_flags(input logic [7:0] st);
        logic [7:0] v;
        expect_reg(2'd1, st, "R8 status before clear");
        reg_read(2'd2, v);
        expect_reg(2'd1, 8'h00, "R8 status after clear");
    endtask

    task automatic slave_bits(input int first, input int last, input logic [7:0] mb,
                              input logic cpol, input logic cpha, input logic lsb);
        for (int i = first; i <= last; i++) begin
            if (!cpha) begin
                sdi = bitof(mb, lsb, i);
                repeat (10) @(negedge clk);
                got[lsb ? i : 7 - i] = sdo;
                sck_i = ~cpol;
                repeat (10) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                sdi = bitof(mb, lsb, i);
                repeat (10) @(negedge clk);
                sck_i = cpol;
                got[lsb ? i : 7 - i] = sdo;
                repeat (10) @(negedge clk);
            end
        end
    endtask

    task automatic ss_low();
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ss_high();
        repeat (6) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(ss_n_o == 1'b1, "R1 select idle", ss_n_o, 1);
        chk(sck_o == 1'b0, "R1 sck idle", sck_o, 0);
        chk(irq == 1'b0, "R1 irq idle", irq, 0);
        expect_reg(2'd0, 8'h04, "R1 control reset");
        expect_reg(2'd1, 8'h00, "R1 status reset");

        // Rate 00, idle low, phase 0, MSB first
        master_run(8'h50, 8'hA5, 8'h3C, -1);
        expect_reg(2'd2, 8'h3C, "R2 R4 R6 received byte");
        expect_reg(2'd1, 8'h80, "R8 flag kept after unarmed data access");
        // R9 interrupt gating
        #1 chk(irq == 1'b0, "R9 irq local enable off", irq, 0);
        serial_int_en = 1'b1;
        reg_write(2'd0, 8'hD0);
        #1 chk(irq == 1'b1, "R9 irq both enables", irq, 1);
        serial_int_en = 1'b0;
        #1 chk(irq == 1'b0, "R9 irq global enable off", irq, 0);
        reg_write(2'd0, 8'h50);
        reg_read(2'd2, v);
        expect_reg(2'd1, 8'h00, "R8 flags cleared by status then data");

        // Rate 01, idle high, phase 1, LSB first, collision mid-transfer
        master_run(8'h7D, 8'h1E, 8'hB1, 5);
        expect_reg(2'd2, 8'hB1, "R7 R4 received byte despite collision");
        clear_flags(8'hC0);

        // Rate 10, idle low, phase 1, MSB first
        master_run(8'h56, 8'hC7, 8'h2D, -1);
        expect_reg(2'd2, 8'h2D, "R3 R6 received byte");
        clear_flags(8'h80);

        // Rate 11, idle high, phase 0, LSB first
        master_run(8'h7B, 8'h69, 8'h4E, -1);
        expect_reg(2'd2, 8'h4E, "R3 R4 received byte");
        clear_flags(8'h80);

        // R11 data survives reset
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        expect_reg(2'd2, 8'h4E, "R11 data kept through reset");
        expect_reg(2'd0, 8'h04, "R1 control after reset");

        // R10 slave, phase 0, idle low, MSB first, partial frame then full
        reg_write(2'd0, 8'h43);
        reg_write(2'd2, 8'h5A);
        ss_low();
        slave_bits(0, 2, 8'h96, 1'b0, 1'b0, 1'b0);
        ss_high();
        expect_reg(2'd1, 8'h00, "R10 no flag after aborted frame");
        reg_write(2'd2, 8'h5A);
        ss_low();
        slave_bits(0, 4, 8'h96, 1'b0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        expect_reg(2'd1, 8'h00, "R10 counter restarted");
        slave_bits(5, 7, 8'h96, 1'b0, 1'b0, 1'b0);
        ss_high();
        chk(got == 8'h5A, "R10 slave bits sent", got, 8'h5A);
        expect_reg(2'd2, 8'h96, "R10 slave received byte");
        clear_flags(8'h80);

        // R10 slave, phase 1, idle high, LSB first
        sck_i = 1'b1;
        reg_write(2'd0, 8'h6C);
        reg_write(2'd2, 8'h3C);
        ss_low();
        slave_bits(0, 7, 8'hE1, 1'b1, 1'b1, 1'b1);
        ss_high();
        chk(got == 8'h3C, "R10 R6 slave phase 1 bits sent", got, 8'h3C);
        expect_reg(2'd2, 8'hE1, "R10 R4 slave phase 1 received byte");
        clear_flags(8'h80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule